// File: doc/BRIEF.md
# Array Element Instruction Select Unit

This unit stands between the broadcast command path of a linear SIMD array and the instruction port of one processing element. Each clock it chooses the byte that the element will execute: one of two opcodes sent to the whole array, a byte of broadcast data, or a fixed no-operation code. A small per-element status register holds a condition bit and a halt bit. The condition bit lets every element run the same pair of opcodes while each picks one according to its own data. The halt bit turns the element off until the array controller turns it back on.

The controller addresses one element at a time with a personal command: a valid strobe, an element address and a two-bit command code. Only the element whose fixed unit number equals the address acts on it. Because a halted element executes nothing, the address match and the status update sit outside the processor. This lets a resume command reach an element that is parked on no-operation. The processor can also write its own status bits while it is running. Each unit drives a registered busy line, and the controller ORs these lines to find out whether any element is still working.

Top module: `pe_isel`

## Requirements
- R1: After a synchronous reset the condition bit is 0 and the halt bit is 0. The instruction output shows the no-operation code (default 0x00) and the busy output is 0.
- R2: With sel_mode = 00 and the element not halted, the output is op_a when the condition bit is 0 and op_b when it is 1.
- R3: With sel_mode = 01 the output is op_a, and with sel_mode = 10 it is op_b, whatever the condition bit holds.
- R4: With sel_mode = 11 the output is bcast_data.
- R5: While the halt bit is 1 the output is the no-operation code for every sel_mode.
- R6: A personal command changes the status only when pcmd_valid is 1 and pcmd_addr equals UNIT_ID (default 3). Address 0 matches no element. The command codes are 00 set condition, 01 clear condition, 10 halt and 11 resume.
- R7: A resume command with a matching address clears the halt bit of a halted element. After that the element follows sel_mode again.
- R8: When the element is not halted, cpu_wr loads cpu_cond and cpu_halt into the status register. cpu_wr is ignored while the element is halted. A matching personal command in the same cycle wins and drops the processor write.
- R9: busy_out is 1 one cycle after busy_in is 1 while the element is not halted, and 0 otherwise.
- R10: The outputs are registered. The instruction output in cycle n+1 follows the select inputs and the status of cycle n. A status change made at an edge takes effect on the output one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_mode | input | 2 | Source select: 00 conditional, 01 op_a, 10 op_b, 11 broadcast data |
| op_a | input | OP_W | First broadcast opcode |
| op_b | input | OP_W | Second broadcast opcode |
| bcast_data | input | OP_W | Broadcast data byte |
| pcmd_valid | input | 1 | Personal command strobe |
| pcmd_addr | input | ADDR_W | Target element number |
| pcmd_code | input | 2 | Personal command code |
| cpu_wr | input | 1 | Processor write of the status register |
| cpu_cond | input | 1 | Condition value written by the processor |
| cpu_halt | input | 1 | Halt value written by the processor |
| busy_in | input | 1 | Processor reports that it is working |
| instr_out | output | OP_W | Byte delivered to the instruction port |
| busy_out | output | 1 | Registered busy line toward the controller OR tree |

## Verification
A wrong condition bit shows up at the ports as soon as conditional mode is selected: the output then carries the wrong one of the two opcodes, one cycle after the select. A stuck or wrongly set halt bit is seen in the next cycle in two places: the no-operation code replaces the selected source, and busy_out reads idle. The bench therefore reads the status back through conditional mode after every command, including after the commands that must be ignored. It compares both outputs on every clock against a behavioural model.

// File: rtl/isel_pkg.sv
package isel_pkg;

  typedef enum logic [1:0] {
    SEL_COND = 2'b00,
    SEL_OPA  = 2'b01,
    SEL_OPB  = 2'b10,
    SEL_DATA = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PC_COND_SET = 2'b00,
    PC_COND_CLR = 2'b01,
    PC_HALT     = 2'b10,
    PC_RESUME   = 2'b11
  } pcmd_e;

  typedef struct packed {
    logic halt;
    logic cond;
  } stat_t;

endpackage

// File: rtl/isel_match.sv
module isel_match #(
  parameter int ADDR_W  = 4,
  parameter int UNIT_ID = 3
) (
  input  logic              pcmd_valid,
  input  logic [ADDR_W-1:0] pcmd_addr,
  output logic              hit
);
  localparam int ADDR_SPAN = 1 << ADDR_W;
  localparam bit REACHABLE = (UNIT_ID > 0) && (UNIT_ID < ADDR_SPAN);

  generate
    if (REACHABLE) begin : g_cmp
      localparam logic [ADDR_W-1:0] MY_ID = ADDR_W'(UNIT_ID);
      // address zero never equals MY_ID because MY_ID is nonzero here
      assign hit = pcmd_valid && (pcmd_addr == MY_ID);
    end else begin : g_none
      logic unused_in;
      assign unused_in = pcmd_valid ^ (^pcmd_addr);
      assign hit = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/isel_status.sv
module isel_status
  import isel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic [1:0] pcmd_code,
  input  logic       cpu_wr,
  input  logic       cpu_cond,
  input  logic       cpu_halt,
  output stat_t      stat_q
);
  stat_t stat_d;
  pcmd_e code;

  assign code = pcmd_e'(pcmd_code);

  always_comb begin
    stat_d = stat_q;
    if (hit) begin
      unique case (code)
        PC_COND_SET: stat_d.cond = 1'b1;
        PC_COND_CLR: stat_d.cond = 1'b0;
        PC_HALT:     stat_d.halt = 1'b1;
        PC_RESUME:   stat_d.halt = 1'b0;
      endcase
    end else if (cpu_wr && !stat_q.halt) begin
      // a halted processor executes nothing, so its writes are dropped
      stat_d.cond = cpu_cond;
      stat_d.halt = cpu_halt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end
endmodule

// File: rtl/isel_mux.sv
module isel_mux
  import isel_pkg::*;
#(
  parameter int              OP_W     = 8,
  parameter logic [OP_W-1:0] NOP_CODE = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  stat_t           stat_q,
  input  logic [1:0]      sel_mode,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic [OP_W-1:0] bcast_data,
  input  logic            busy_in,
  output logic [OP_W-1:0] instr_out,
  output logic            busy_out
);
  logic [OP_W-1:0] pick;
  sel_e            sel;

  assign sel = sel_e'(sel_mode);

  always_comb begin
    unique case (sel)
      SEL_COND: pick = stat_q.cond ? op_b : op_a;
      SEL_OPA:  pick = op_a;
      SEL_OPB:  pick = op_b;
      SEL_DATA: pick = bcast_data;
    endcase
    if (stat_q.halt) pick = NOP_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_out <= NOP_CODE;
      busy_out  <= 1'b0;
    end else begin
      instr_out <= pick;
      busy_out  <= busy_in && !stat_q.halt;
    end
  end
endmodule

// File: rtl/pe_isel.sv
module pe_isel
  import isel_pkg::*;
#(
  parameter int              OP_W     = 8,
  parameter int              ADDR_W   = 4,
  parameter int              UNIT_ID  = 3,
  parameter logic [OP_W-1:0] NOP_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sel_mode,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  input  logic [OP_W-1:0]   bcast_data,
  input  logic              pcmd_valid,
  input  logic [ADDR_W-1:0] pcmd_addr,
  input  logic [1:0]        pcmd_code,
  input  logic              cpu_wr,
  input  logic              cpu_cond,
  input  logic              cpu_halt,
  input  logic              busy_in,
  output logic [OP_W-1:0]   instr_out,
  output logic              busy_out
);
  logic  hit;
  stat_t stat_q;

  isel_match #(.ADDR_W(ADDR_W), .UNIT_ID(UNIT_ID)) u_match (
    .pcmd_valid(pcmd_valid),
    .pcmd_addr (pcmd_addr),
    .hit       (hit)
  );

  isel_status u_status (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .pcmd_code(pcmd_code),
    .cpu_wr   (cpu_wr),
    .cpu_cond (cpu_cond),
    .cpu_halt (cpu_halt),
    .stat_q   (stat_q)
  );

  isel_mux #(.OP_W(OP_W), .NOP_CODE(NOP_CODE)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .stat_q    (stat_q),
    .sel_mode  (sel_mode),
    .op_a      (op_a),
    .op_b      (op_b),
    .bcast_data(bcast_data),
    .busy_in   (busy_in),
    .instr_out (instr_out),
    .busy_out  (busy_out)
  );
endmodule

// File: rtl/isel_checker.sv
module isel_checker #(
  parameter int              OP_W     = 8,
  parameter int              ADDR_W   = 4,
  parameter int              UNIT_ID  = 3,
  parameter logic [OP_W-1:0] NOP_CODE = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        sel_mode,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic              pcmd_valid,
  input logic [ADDR_W-1:0] pcmd_addr,
  input logic [1:0]        pcmd_code,
  input logic              cpu_wr,
  input logic              busy_in,
  input logic              st_halt,
  input logic              st_cond,
  input logic [OP_W-1:0]   instr_out,
  input logic              busy_out
);
  logic addr_hit;
  assign addr_hit = pcmd_valid && (pcmd_addr != '0) && (int'(pcmd_addr) == UNIT_ID);

  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (instr_out == NOP_CODE) && !busy_out && !st_halt && !st_cond);

  a_r2_cond_picks_b: assert property (@(posedge clk) disable iff (rst)
    (!st_halt && sel_mode == 2'b00 && st_cond) |=> instr_out == $past(op_b));

  a_r3_force_a: assert property (@(posedge clk) disable iff (rst)
    (!st_halt && sel_mode == 2'b01) |=> instr_out == $past(op_a));

  a_r5_halt_nop: assert property (@(posedge clk) disable iff (rst)
    st_halt |=> instr_out == NOP_CODE);

  a_r6_foreign_ignored: assert property (@(posedge clk) disable iff (rst)
    (!addr_hit && !cpu_wr) |=> $stable(st_halt) && $stable(st_cond));

  a_r7_resume: assert property (@(posedge clk) disable iff (rst)
    (addr_hit && pcmd_code == 2'b11) |=> !st_halt);

  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    (busy_in && !st_halt) |=> busy_out);
endmodule

bind pe_isel isel_checker #(
  .OP_W(OP_W), .ADDR_W(ADDR_W), .UNIT_ID(UNIT_ID), .NOP_CODE(NOP_CODE)
) chk (
  .clk       (clk),
  .rst       (rst),
  .sel_mode  (sel_mode),
  .op_a      (op_a),
  .op_b      (op_b),
  .pcmd_valid(pcmd_valid),
  .pcmd_addr (pcmd_addr),
  .pcmd_code (pcmd_code),
  .cpu_wr    (cpu_wr),
  .busy_in   (busy_in),
  .st_halt   (stat_q.halt),
  .st_cond   (stat_q.cond),
  .instr_out (instr_out),
  .busy_out  (busy_out)
);

// File: tb/pe_isel_test.sv
module pe_isel_test;
  localparam int OP_W = 8;
  localparam int ADDR_W = 4;
  localparam int ID = 3;
  localparam logic [7:0] NOP = 8'h00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sel_mode = 2'b00;
  logic [7:0] op_a = 8'h00, op_b = 8'h00, bcast_data = 8'h00;
  logic pcmd_valid = 1'b0;
  logic [3:0] pcmd_addr = 4'd0;
  logic [1:0] pcmd_code = 2'b00;
  logic cpu_wr = 1'b0, cpu_cond = 1'b0, cpu_halt = 1'b0, busy_in = 1'b0;
  logic [7:0] instr_out;
  logic busy_out;

  int checks = 0;
  int errors = 0;
  bit m_cond = 0, m_halt = 0;
  logic [7:0] exp_instr = NOP;
  bit exp_busy = 0;

  always #2 clk = ~clk;

  pe_isel #(.OP_W(OP_W), .ADDR_W(ADDR_W), .UNIT_ID(ID), .NOP_CODE(NOP)) uut (
    .clk(clk), .rst(rst), .sel_mode(sel_mode), .op_a(op_a), .op_b(op_b),
    .bcast_data(bcast_data), .pcmd_valid(pcmd_valid), .pcmd_addr(pcmd_addr),
    .pcmd_code(pcmd_code), .cpu_wr(cpu_wr), .cpu_cond(cpu_cond),
    .cpu_halt(cpu_halt), .busy_in(busy_in), .instr_out(instr_out),
    .busy_out(busy_out)
  );

  // one clock: model computes what the registers will hold after the edge
  task automatic step(input string tag);
    bit hit;
    if (rst) begin
      exp_instr = NOP; exp_busy = 0; m_cond = 0; m_halt = 0;
    end else begin
      if (m_halt) exp_instr = NOP;
      else case (sel_mode)
        2'b00: exp_instr = m_cond ? op_b : op_a;
        2'b01: exp_instr = op_a;
        2'b10: exp_instr = op_b;
        default: exp_instr = bcast_data;
      endcase
      exp_busy = busy_in && !m_halt;
      hit = pcmd_valid && pcmd_addr != 0 && int'(pcmd_addr) == ID;
      if (hit) begin
        case (pcmd_code)
          2'b00: m_cond = 1;
          2'b01: m_cond = 0;
          2'b10: m_halt = 1;
          default: m_halt = 0;
        endcase
      end else if (cpu_wr && !m_halt) begin
        m_cond = cpu_cond; m_halt = cpu_halt;
      end
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (instr_out !== exp_instr || busy_out !== exp_busy) begin
      errors++;
      $display("FAIL %s: instr=%h busy=%b expected instr=%h busy=%b",
               tag, instr_out, busy_out, exp_instr, exp_busy);
    end
  endtask

  task automatic idle_cmds();
    pcmd_valid = 0; cpu_wr = 0;
  endtask

  task automatic pcmd(input logic [3:0] a, input logic [1:0] c, input string tag);
    pcmd_valid = 1; pcmd_addr = a; pcmd_code = c;
    step(tag);
    idle_cmds();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rst = 0;
    op_a = 8'h3C; op_b = 8'hC5; bcast_data = 8'h7E;
    sel_mode = 2'b01; step("R3 force a");
    sel_mode = 2'b10; step("R3 force b");
    sel_mode = 2'b11; step("R4 broadcast");
    sel_mode = 2'b00; step("R2 cond=0 gives a");
    busy_in = 1; step("R9 busy");
    busy_in = 0;
    pcmd(4'd3, 2'b00, "R6 set cond");
    step("R2 cond=1 gives b");
    sel_mode = 2'b01; step("R3 cond ignored");
    sel_mode = 2'b00;
    pcmd(4'd5, 2'b01, "R6 foreign clear");
    step("R6 cond kept");
    pcmd(4'd0, 2'b01, "R6 addr zero");
    step("R6 cond kept after addr 0");
    pcmd_addr = 4'd3; pcmd_code = 2'b01; step("R6 no strobe");
    step("R6 cond kept no strobe");
    cpu_wr = 1; cpu_cond = 0; cpu_halt = 0; step("R8 cpu write");
    idle_cmds();
    step("R8 cond cleared by cpu");
    pcmd(4'd3, 2'b10, "R5 halt");
    busy_in = 1;
    for (int m = 0; m < 4; m++) begin
      sel_mode = 2'(m); step("R5 nop while halted");
    end
    cpu_wr = 1; cpu_halt = 0; cpu_cond = 1; step("R8 write while halted");
    idle_cmds();
    step("R8 still halted");
    pcmd(4'd2, 2'b11, "R6 foreign resume");
    step("R6 still halted");
    pcmd(4'd3, 2'b11, "R7 resume");
    sel_mode = 2'b00; step("R7 running again");
    busy_in = 0;
    // same-cycle conflict: personal command wins
    pcmd_valid = 1; pcmd_addr = 4'd3; pcmd_code = 2'b00;
    cpu_wr = 1; cpu_cond = 0; cpu_halt = 1; step("R8 conflict");
    idle_cmds();
    step("R8 pcmd won, cond=1 halt=0");
    cpu_wr = 1; cpu_cond = 0; cpu_halt = 1; step("R8 cpu self halt");
    idle_cmds();
    step("R5 halted by cpu");
    pcmd(4'd3, 2'b11, "R7 resume after cpu halt");
    // varied data patterns, output tracks inputs with one cycle lag
    for (int i = 0; i < 40; i++) begin
      op_a = 8'(i * 37 + 1); op_b = 8'(i * 91 + 7); bcast_data = 8'(i * 13);
      sel_mode = 2'(i % 4); busy_in = i[0];
      if (i % 7 == 3) begin
        pcmd_valid = 1; pcmd_addr = 4'(i % 5); pcmd_code = 2'(i % 3);
      end
      step("R10 pattern");
      idle_cmds();
    end
    pcmd(4'd3, 2'b11, "R7 final resume");
    rst = 1; step("R1 reset again");
    rst = 0; sel_mode = 2'b00; step("R1 cond cleared by reset");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule